// File: doc/BRIEF.md
# Reconfigurable Multi-Input Signature Register

This block is a small self-test register built on an internal-XOR linear feedback shift register. One mode input switches it between four jobs. It can hold its contents. It can run free as a pseudorandom pattern generator. It can fold a parallel bus into a running signature on every clock. It can act as a plain serial shift chain, so that a finished signature can be read out through a scan path.

The feedback follows the polynomial 1 + x^2 + x^3 in Galois form. The XOR gates sit between stages, and the last stage feeds back. In compaction mode each stage also takes one bit of the data bus. A parameter sets how many bus bits take part. Bits above that count get no XOR and have no effect.

A synchronous active-low init loads the state. The load value depends on the mode present at that edge: the generator seed in generate mode, and all zeros otherwise, which is the clean start for a signature. A combinational flag compares the state on chip with a known-good signature that is fixed by a parameter.

Top module: `bilbo_sigreg`

## Requirements
- R1: When init_n is low at a rising clock edge, the state q is loaded with 3'b100 (q[2] set) if mode is 01, and with 3'b000 for any other mode. The data and scan inputs are ignored on that edge.
- R2: Mode 00 (hold): the state q stays unchanged across the edge, whatever data_in and scan_in are.
- R3: Mode 01 (generate): the next state is computed with fb = q[2] as q'[0] = fb, q'[1] = q[0] and q'[2] = q[1] ^ fb. data_in and scan_in are ignored.
- R4: Generate mode started from 3'b100 passes through seven distinct nonzero states and returns to 3'b100 after exactly seven edges.
- R5: Mode 10 (compact): the next state is the generate-mode next state XORed bit by bit with data_in, where data_in[i] enters stage i.
- R6: With USED_INPUTS = m below the width, data_in bits at positions m and above have no effect on the state in compact mode.
- R7: Mode 11 (scan): q'[0] = scan_in and q'[i] = q[i-1] for i >= 1, with no feedback. data_in is ignored.
- R8: scan_out always equals the last stage q[2]. Three scan edges therefore present q[2], q[1] and q[0] in that order.
- R9: sig_ok is high exactly when q equals GOLDEN_SIG (default 3'b011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| init_n | input | 1 | Synchronous active-low init; the value loaded depends on mode |
| mode | input | 2 | 00 hold, 01 generate, 10 compact, 11 scan shift |
| data_in | input | 3 | Parallel bus folded into the signature; bit i feeds stage i |
| scan_in | input | 1 | Serial input to stage 0 in scan mode |
| scan_out | output | 1 | Last stage, the serial output |
| q | output | 3 | Parallel register state |
| sig_ok | output | 1 | High when q equals the known-good signature |

## Verification
The assertions assume that mode, data_in and scan_in are settled before each rising edge. They also assume that init_n is held low across at least one edge before any checking starts, because the register has no other reset. The bench changes every input only on the falling clock edge. It keeps init_n low through the first edges and then pulses it low now and then during a long random run, drawn from a fixed seed, that covers all four modes. Directed sequences add the generator period, the tied-off upper input and a full shift-out of a signature.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD    = 2'b00,
      MODE_GEN     = 2'b01,
      MODE_COMPACT = 2'b10,
      MODE_SCAN    = 2'b11
   } bilbo_mode_e;
endpackage

// File: rtl/bilbo_next.sv
// Next-state network: Galois feedback, masked parallel inputs, and the scan path.
module bilbo_next
   import bilbo_pkg::*;
#(
   parameter int unsigned WIDTH       = 3,
   parameter logic [WIDTH-1:0] TAPS   = 3'b101,
   parameter int unsigned USED_INPUTS = WIDTH
) (
   input  bilbo_mode_e      mode,
   input  logic [WIDTH-1:0] state,
   input  logic [WIDTH-1:0] data_in,
   input  logic             scan_in,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] IN_MASK =
      (USED_INPUTS >= WIDTH) ? {WIDTH{1'b1}} : WIDTH'((1 << USED_INPUTS) - 1);

   logic             fb;
   logic [WIDTH-1:0] gen_bits;
   logic [WIDTH-1:0] shift_bits;
   logic [WIDTH-1:0] folded;

   assign fb            = state[WIDTH-1];
   assign gen_bits[0]   = fb;
   assign shift_bits[0] = scan_in;

   for (genvar i = 1; i < WIDTH; i++) begin : g_stage
      if (TAPS[i]) begin : g_tap
         assign gen_bits[i] = state[i-1] ^ fb;
      end else begin : g_plain
         assign gen_bits[i] = state[i-1];
      end
      assign shift_bits[i] = state[i-1];
   end

   // Unused upper inputs are masked off; their XORs reduce to wires.
   assign folded = gen_bits ^ (data_in & IN_MASK);

   always_comb begin
      unique case (mode)
         MODE_HOLD:    nxt = state;
         MODE_GEN:     nxt = gen_bits;
         MODE_COMPACT: nxt = folded;
         MODE_SCAN:    nxt = shift_bits;
         default:      nxt = state;
      endcase
   end
endmodule

// File: rtl/bilbo_state.sv
// State register with mode-dependent synchronous init.
module bilbo_state
   import bilbo_pkg::*;
#(
   parameter int unsigned WIDTH     = 3,
   parameter logic [WIDTH-1:0] SEED = 3'b100
) (
   input  logic             clk,
   input  logic             init_n,
   input  bilbo_mode_e      mode,
   input  logic             scan_in,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] state
);
   always_ff @(posedge clk) begin
      if (!init_n) state <= (mode == MODE_GEN) ? SEED : '0;
      else         state <= nxt;
   end

   // R1: a generate-mode init leaves the seed in place
   assert_seed_load_R1: assert property (@(posedge clk) disable iff (!init_n)
      ($rose(init_n) && $past(mode) == MODE_GEN) |-> state == SEED);
   // R1: any other init clears the register
   assert_clear_load_R1: assert property (@(posedge clk) disable iff (!init_n)
      ($rose(init_n) && $past(mode) != MODE_GEN) |-> state == '0);
   // R2: hold freezes the state
   assert_hold_R2: assert property (@(posedge clk) disable iff (!init_n)
      (mode == MODE_HOLD) |=> $stable(state));
   // R4: the generator never falls into the all-zero lock-up state
   assert_gen_nonzero_R4: assert property (@(posedge clk) disable iff (!init_n)
      (mode == MODE_GEN && state != '0) |=> state != '0);
   // R7: scan is a pure shift with no feedback
   assert_scan_shift_R7: assert property (@(posedge clk) disable iff (!init_n)
      (mode == MODE_SCAN) |=>
      (state[0] == $past(scan_in) && state[WIDTH-1:1] == $past(state[WIDTH-2:0])));
endmodule

// File: rtl/bilbo_cmp.sv
// On-chip comparison with the known-good signature.
module bilbo_cmp #(
   parameter int unsigned WIDTH       = 3,
   parameter logic [WIDTH-1:0] GOLDEN = 3'b011
) (
   input  logic [WIDTH-1:0] state,
   output logic             match
);
   assign match = (state == GOLDEN);
endmodule

// File: rtl/bilbo_sigreg.sv
module bilbo_sigreg
   import bilbo_pkg::*;
#(
   parameter int unsigned WIDTH           = 3,
   parameter logic [WIDTH-1:0] TAPS       = 3'b101,
   parameter int unsigned USED_INPUTS     = WIDTH,
   parameter logic [WIDTH-1:0] SEED       = 3'b100,
   parameter logic [WIDTH-1:0] GOLDEN_SIG = 3'b011
) (
   input  logic             clk,
   input  logic             init_n,
   input  logic [1:0]       mode,
   input  logic [WIDTH-1:0] data_in,
   input  logic             scan_in,
   output logic             scan_out,
   output logic [WIDTH-1:0] q,
   output logic             sig_ok
);
   if (WIDTH < 2) begin : g_bad_width
      $error("bilbo_sigreg: WIDTH must be at least 2");
   end
   if (USED_INPUTS < 1 || USED_INPUTS > WIDTH) begin : g_bad_used
      $error("bilbo_sigreg: USED_INPUTS must lie in 1..WIDTH");
   end
   if (TAPS[0] != 1'b1) begin : g_bad_taps
      $error("bilbo_sigreg: constant term of the polynomial must be set");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("bilbo_sigreg: an all-zero seed locks the generator");
   end

   bilbo_mode_e      mode_e;
   logic [WIDTH-1:0] nxt;

   assign mode_e = bilbo_mode_e'(mode);

   bilbo_next #(.WIDTH(WIDTH), .TAPS(TAPS), .USED_INPUTS(USED_INPUTS)) u_next (
      .mode(mode_e), .state(q), .data_in(data_in), .scan_in(scan_in), .nxt(nxt));

   bilbo_state #(.WIDTH(WIDTH), .SEED(SEED)) u_state (
      .clk(clk), .init_n(init_n), .mode(mode_e), .scan_in(scan_in),
      .nxt(nxt), .state(q));

   bilbo_cmp #(.WIDTH(WIDTH), .GOLDEN(GOLDEN_SIG)) u_cmp (
      .state(q), .match(sig_ok));

   assign scan_out = q[WIDTH-1];
endmodule

// File: tb/tb_bilbo_sigreg.sv
module tb_bilbo_sigreg;
   logic       clk = 1'b0;
   logic       init_n = 1'b0;
   logic [1:0] mode = 2'b10;
   logic [2:0] data_in = 3'b000;
   logic       scan_in = 1'b0;
   logic       so_a, so_b, ok_a, ok_b;
   logic [2:0] q_a, q_b;
   logic [2:0] m_a, m_b;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bilbo_sigreg dut (.clk(clk), .init_n(init_n), .mode(mode), .data_in(data_in),
      .scan_in(scan_in), .scan_out(so_a), .q(q_a), .sig_ok(ok_a));
   bilbo_sigreg #(.USED_INPUTS(2)) dut_m2 (.clk(clk), .init_n(init_n), .mode(mode),
      .data_in(data_in), .scan_in(scan_in), .scan_out(so_b), .q(q_b), .sig_ok(ok_b));

   function automatic logic [2:0] ref_next(logic [2:0] s, logic [1:0] md,
                                           logic [2:0] d, logic si, int used);
      logic [2:0] g;
      logic [2:0] dm;
      g  = {s[1] ^ s[2], s[0], s[2]};
      dm = (used >= 3) ? d : (d & 3'b011);
      case (md)
         2'b00:   return s;
         2'b01:   return g;
         2'b10:   return g ^ dm;
         default: return {s[1], s[0], si};
      endcase
   endfunction

   task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   function automatic string mode_tag(logic [1:0] md);
      case (md)
         2'b00:   return "R2 hold";
         2'b01:   return "R3 generate";
         2'b10:   return "R5 compact";
         default: return "R7 scan";
      endcase
   endfunction

   // One clock: inputs applied at the falling edge, outputs checked at the next falling edge.
   task automatic step(logic in_n, logic [1:0] md, logic [2:0] d, logic si, string tag);
      init_n = in_n; mode = md; data_in = d; scan_in = si;
      @(posedge clk);
      if (!in_n) begin
         m_a = (md == 2'b01) ? 3'b100 : 3'b000;
         m_b = m_a;
      end else begin
         m_a = ref_next(m_a, md, d, si, 3);
         m_b = ref_next(m_b, md, d, si, 2);
      end
      @(negedge clk);
      chk(tag, q_a, m_a);
      chk({tag, " R6 two-input copy"}, q_b, m_b);
      chk("R8 scan_out", {2'b00, so_a}, {2'b00, m_a[2]});
      chk("R9 sig_ok", {2'b00, ok_a}, {2'b00, (m_a == 3'b011)});
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] seen;
      logic [2:0] sig;
      void'($urandom(32'h5eed_1234));
      m_a = 3'b000; m_b = 3'b000;
      @(negedge clk);
      // R1: clear and seed loads
      step(1'b0, 2'b10, 3'b111, 1'b1, "R1 clear init");
      step(1'b0, 2'b01, 3'b111, 1'b1, "R1 seed init");
      chk("R1 seed value", q_a, 3'b100);
      // R4: generator period from the seed
      seen = 8'h00;
      for (int k = 0; k < 7; k++) begin
         seen[q_a] = 1'b1;
         step(1'b1, 2'b01, 3'($urandom()), 1'($urandom()), "R3 generate");
      end
      chk("R4 back to seed after 7", q_a, 3'b100);
      chk("R4 seven distinct nonzero", seen[2:0], 3'b110);
      chk("R4 seven distinct nonzero hi", seen[7:3], 5'b11111);
      // R6: tied-off top input
      step(1'b0, 2'b10, 3'b000, 1'b0, "R1 clear init");
      step(1'b1, 2'b10, 3'b100, 1'b0, "R5 compact top bit");
      chk("R5 full-width takes top bit", q_a, 3'b100);
      chk("R6 top bit ignored", q_b, 3'b000);
      // R5/R8: build a signature, then shift it out
      step(1'b1, 2'b10, 3'b011, 1'b0, "R5 compact");
      step(1'b1, 2'b10, 3'b110, 1'b0, "R5 compact");
      sig = q_a;
      for (int k = 0; k < 3; k++) begin
         chk("R8 shift-out bit order", {2'b00, so_a}, {2'b00, sig[2-k]});
         step(1'b1, 2'b11, 3'b111, 1'b0, "R7 scan");
      end
      chk("R7 chain filled with scan_in", q_a, 3'b000);
      // R9: shift the known-good value in
      step(1'b1, 2'b11, 3'b000, 1'b0, "R7 scan");
      step(1'b1, 2'b11, 3'b000, 1'b1, "R7 scan");
      step(1'b1, 2'b11, 3'b000, 1'b1, "R7 scan");
      chk("R9 golden reached", {2'b00, ok_a}, 3'b001);
      // Random mix over all modes
      for (int k = 0; k < 1500; k++) begin
         logic [1:0] md;
         logic in_n;
         md   = 2'($urandom());
         in_n = (($urandom() % 20) != 0);
         step(in_n, md, 3'($urandom()), 1'($urandom()), in_n ? mode_tag(md) : "R1 init");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule